// File: doc/BRIEF.md
# Variable-Width Sample Gearbox with Training Alignment

This block sits behind a fixed serial-to-parallel front end that delivers one 8-bit word per eight serial bit periods. The converter feeding that front end can run at 6, 8 or 12 bits per sample. The block joins the incoming words into a continuous bit stream and cuts it into samples of the selected width. A sample whose bits straddle two input words is assembled from the tail of one word and the head of the next. Each finished sample is announced by a one-cycle valid strobe.

The sample boundary is found with a training mode. While training is on, every emitted sample is compared against an expected pattern. On a mismatch, one extra bit is thrown away before the next sample, which moves the cut point one bit later in the stream. After a run of consecutive matches, an aligned flag is raised.

The block runs entirely in the word clock domain. The input valid marks cycles that carry a word, and the output valid marks the sample rate. No divided clock is used.

Top module: `gbx_deser_gearbox`

## Requirements
- R1: During and right after reset, `sample_vld_o` and `aligned_o` are 0.
- R2: Bits are taken MSB-first: the earliest received bit of a sample lands in bit W-1 of `sample_o`, where W is the selected width, and bits W and above of `sample_o` are 0 whenever `sample_vld_o` is 1.
- R3: `res_sel_i` selects the width W: code 0 gives 6, code 1 gives 8, and codes 2 and 3 both give 12.
- R4: Outside training, successive samples are successive, non-overlapping W-bit slices of the bit stream formed by the accepted words in arrival order, joined across word boundaries with no bit lost or repeated.
- R5: Over a whole number of word groups, the sample count is 8/W times the word count: one sample per word at 8 bits, two per three words at 12 bits, and four per three words at 6 bits.
- R6: `sample_vld_o` is high in the cycle after the clock edge at which the bits held, including any word accepted at that edge, first reach W. At most one sample is emitted per cycle.
- R7: A change of `res_sel_i` code empties the accumulator, drops the word presented in that cycle, suppresses the output strobe, and clears `aligned_o` at that edge.
- R8: In training mode, a sample that differs from the low W bits of `pattern_i` causes one stream bit to be discarded, so the next sample begins W+1 bits after the start of the mismatching one.
- R9: In training mode, `aligned_o` rises together with the strobe of the LOCK_N-th consecutive matching sample (LOCK_N defaults to 4). A mismatch clears both `aligned_o` and the run count.
- R10: A rising edge of `train_i` clears `aligned_o` and the run count. While `train_i` is 0, no bit is discarded and `aligned_o` keeps its value.
- R11: The accumulator never holds more than ACC_W bits. Because at most one sample leaves per cycle, 6-bit operation needs input words on no more than three of every four cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_i | input | 1 | Synchronous active-high reset |
| word_i | input | IN_W | Parallel word from the front end, earliest bit in the MSB |
| word_vld_i | input | 1 | Marks a cycle carrying a new word |
| res_sel_i | input | 2 | Sample width code (0: 6, 1: 8, 2/3: 12) |
| train_i | input | 1 | Training mode enable |
| pattern_i | input | MAX_W | Expected training sample in the low W bits |
| sample_o | output | MAX_W | Completed sample, right-justified |
| sample_vld_o | output | 1 | One-cycle strobe per completed sample |
| aligned_o | output | 1 | Set after LOCK_N consecutive training matches |

## Verification
The bench uses the default parameters: 8-bit words, a 12-bit sample ceiling, a 24-bit accumulator and a lock run of four. With these values, every width code, including the duplicate 12-bit code, can be swept over a long stream. The bench also steps the training start offset through every bit position of each width. That brings every split of a sample across word boundaries within reach, along with every number of slips before lock and both ways of clearing the aligned flag. Expected samples, strobes and flag states come from a bit-position model that follows the requirements.

// File: rtl/gbx_pkg.sv
package gbx_pkg;

   typedef enum logic [1:0] {
      RES_6   = 2'd0,
      RES_8   = 2'd1,
      RES_12  = 2'd2,
      RES_12X = 2'd3
   } res_e;

   // width in bits selected by a resolution code
   function automatic int unsigned res_width(input logic [1:0] code);
      case (res_e'(code))
         RES_6:   return 6;
         RES_8:   return 8;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/gbx_accum.sv
module gbx_accum #(
   parameter int IN_W  = 8,
   parameter int MAX_W = 12,
   parameter int ACC_W = 24,
   parameter int FW    = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             flush_i,
   input  logic [IN_W-1:0]  word_i,
   input  logic             word_vld_i,
   input  logic [FW-1:0]    width_i,
   input  logic             slip_i,
   output logic             emit_o,
   output logic [MAX_W-1:0] smp_o,
   output logic [MAX_W-1:0] sample_o,
   output logic             sample_vld_o
);

   localparam int PAD_W = ACC_W - IN_W;

   logic [ACC_W-1:0] acc_q, word_al, cat, cat2, acc_n;
   logic [FW-1:0]    fill_q, avail_in, avail2, fill_n;
   logic [MAX_W-1:0] top_bits;
   logic             skip_q, drop;

   // bits held are MSB-aligned in acc_q; new word goes just below them
   always_comb begin
      word_al  = {word_i, {PAD_W{1'b0}}} >> fill_q;
      avail_in = fill_q + (word_vld_i ? FW'(IN_W) : FW'(0));
      cat      = word_vld_i ? (acc_q | word_al) : acc_q;
      drop     = skip_q && (avail_in != '0);
      cat2     = drop ? (cat << 1) : cat;
      avail2   = avail_in - FW'(drop);
      emit_o   = (avail2 >= width_i);
      top_bits = cat2[ACC_W-1 -: MAX_W];
      smp_o    = top_bits >> (FW'(MAX_W) - width_i);
      acc_n    = emit_o ? (cat2 << width_i) : cat2;
      fill_n   = emit_o ? (avail2 - width_i) : avail2;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i || flush_i) begin
         acc_q        <= '0;
         fill_q       <= '0;
         skip_q       <= 1'b0;
         sample_vld_o <= 1'b0;
         sample_o     <= '0;
      end else begin
         acc_q        <= acc_n;
         fill_q       <= fill_n;
         skip_q       <= (skip_q && !drop) || slip_i;
         sample_vld_o <= emit_o;
         if (emit_o) sample_o <= smp_o;
      end
   end

   // R11: incoming bits always fit in the accumulator
   p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (rst_i)
      !flush_i |-> (avail_in <= FW'(ACC_W)));

   // R7: a flush cycle produces no strobe
   p_flush_quiet_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      flush_i |=> !sample_vld_o);

   // R6: after an emit the remainder is below one sample
   p_remainder_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      (emit_o && !flush_i && !word_vld_i) |=> (fill_q < $past(width_i) + FW'(IN_W)));

endmodule

// File: rtl/gbx_align.sv
module gbx_align #(
   parameter int MAX_W  = 12,
   parameter int LOCK_N = 4,
   parameter int FW     = 6
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             restart_i,
   input  logic             train_i,
   input  logic             emit_i,
   input  logic [MAX_W-1:0] smp_i,
   input  logic [MAX_W-1:0] pattern_i,
   input  logic [FW-1:0]    width_i,
   output logic             slip_o,
   output logic             aligned_o
);

   localparam int CW = $clog2(LOCK_N + 1);

   logic [MAX_W-1:0] mask;
   logic [CW-1:0]    run_q;
   logic             match;

   for (genvar b = 0; b < MAX_W; b++) begin : g_mask
      assign mask[b] = (FW'(b) < width_i);
   end

   assign match  = (smp_i == (pattern_i & mask));
   assign slip_o = train_i && emit_i && !match && !restart_i;

   always_ff @(posedge clk_i) begin
      if (rst_i || restart_i) begin
         run_q     <= '0;
         aligned_o <= 1'b0;
      end else if (train_i && emit_i) begin
         if (match) begin
            if (int'(run_q) < LOCK_N) run_q <= run_q + 1'b1;
            if (int'(run_q) + 1 >= LOCK_N) aligned_o <= 1'b1;
         end else begin
            run_q     <= '0;
            aligned_o <= 1'b0;
         end
      end
   end

   // R10: restart always drops the flag
   p_restart_clears_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      restart_i |=> !aligned_o);

   // R10: outside training the flag is frozen
   p_hold_untrained_r10: assert property (@(posedge clk_i) disable iff (rst_i)
      (!train_i && !restart_i) |=> $stable(aligned_o));

   // R9: lock only follows a matching training sample
   p_lock_on_match_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(aligned_o) |-> $past(train_i && emit_i && match));

   // R9: a training mismatch clears the flag
   p_mismatch_clears_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      slip_o |=> !aligned_o);

endmodule

// File: rtl/gbx_deser_gearbox.sv
module gbx_deser_gearbox #(
   parameter int IN_W   = 8,
   parameter int MAX_W  = 12,
   parameter int ACC_W  = 24,
   parameter int LOCK_N = 4
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [IN_W-1:0]  word_i,
   input  logic             word_vld_i,
   input  logic [1:0]       res_sel_i,
   input  logic             train_i,
   input  logic [MAX_W-1:0] pattern_i,
   output logic [MAX_W-1:0] sample_o,
   output logic             sample_vld_o,
   output logic             aligned_o
);
   import gbx_pkg::*;

   localparam int FW = $clog2(ACC_W + IN_W + 1);

   if (MAX_W < 12) begin : g_chk_maxw
      $error("MAX_W must hold the widest sample");
   end
   if (ACC_W < MAX_W + IN_W) begin : g_chk_acc
      $error("ACC_W too small for a partial sample plus one word");
   end
   if (LOCK_N < 1) begin : g_chk_lock
      $error("LOCK_N must be at least 1");
   end

   logic [1:0]       res_q;
   logic             train_q, flush, restart, emit, slip;
   logic [FW-1:0]    width_c;
   logic [MAX_W-1:0] smp_c;

   assign width_c = FW'(res_width(res_sel_i));
   assign flush   = (res_sel_i != res_q);
   assign restart = flush || (train_i && !train_q);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         res_q   <= res_sel_i;
         train_q <= 1'b0;
      end else begin
         res_q   <= res_sel_i;
         train_q <= train_i;
      end
   end

   gbx_accum #(.IN_W(IN_W), .MAX_W(MAX_W), .ACC_W(ACC_W), .FW(FW)) u_accum (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .flush_i     (flush),
      .word_i      (word_i),
      .word_vld_i  (word_vld_i),
      .width_i     (width_c),
      .slip_i      (slip),
      .emit_o      (emit),
      .smp_o       (smp_c),
      .sample_o    (sample_o),
      .sample_vld_o(sample_vld_o)
   );

   gbx_align #(.MAX_W(MAX_W), .LOCK_N(LOCK_N), .FW(FW)) u_align (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .restart_i(restart),
      .train_i  (train_i),
      .emit_i   (emit),
      .smp_i    (smp_c),
      .pattern_i(pattern_i),
      .width_i  (width_c),
      .slip_o   (slip),
      .aligned_o(aligned_o)
   );

   // R2: nothing above the selected width
   p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (sample_vld_o && !flush) |-> ((sample_o >> width_c) == '0));

   // R7: a code change clears the flag
   p_flush_unlocks_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      flush |=> !aligned_o);

endmodule

// File: tb/gbx_deser_gearbox_tb.sv
`timescale 1ns/1ps
module gbx_deser_gearbox_tb;

   logic        clk = 1'b0;
   logic        rst_i;
   logic [7:0]  word_i;
   logic        word_vld_i;
   logic [1:0]  res_sel_i;
   logic        train_i;
   logic [11:0] pattern_i;
   logic [11:0] sample_o;
   logic        sample_vld_o;
   logic        aligned_o;

   always #4 clk = ~clk;

   gbx_deser_gearbox u_dut (
      .clk_i(clk), .rst_i(rst_i), .word_i(word_i), .word_vld_i(word_vld_i),
      .res_sel_i(res_sel_i), .train_i(train_i), .pattern_i(pattern_i),
      .sample_o(sample_o), .sample_vld_o(sample_vld_o), .aligned_o(aligned_o)
   );

   int checks = 0;
   int errors = 0;
   int nsamp  = 0;

   // bit-position model
   bit bq [0:8191];
   int wr, rd, consec;
   logic [1:0] m_res;
   bit m_tr, m_al;

   function automatic int wof(input logic [1:0] c);
      return (c == 2'd0) ? 6 : (c == 2'd1) ? 8 : 12;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // called at a negedge: drive, let one edge pass, check at next negedge
   task automatic cyc(input logic [7:0] w, input logic v);
      bit ev;
      logic [11:0] es;
      int W;
      bit rise;
      ev = 0; es = '0;
      word_i = w; word_vld_i = v;
      @(posedge clk);
      rise = train_i && !m_tr;
      if (res_sel_i != m_res) begin
         m_res = res_sel_i; wr = 0; rd = 0; consec = 0; m_al = 0;
      end else begin
         W = wof(m_res);
         if (rise) begin consec = 0; m_al = 0; end
         if (v) for (int j = 0; j < 8; j++) begin bq[wr] = w[7-j]; wr++; end
         if (wr - rd >= W) begin
            ev = 1;
            for (int j = 0; j < W; j++) es = {es[10:0], bq[rd+j]};
            rd += W;
            if (train_i && !rise) begin
               if (es == (pattern_i & ((12'h1 << W) - 12'h1))) begin
                  consec++;
                  if (consec >= 4) m_al = 1;
               end else begin
                  consec = 0; m_al = 0; rd += 1;
               end
            end
         end
      end
      m_tr = train_i;
      @(negedge clk);
      chk(sample_vld_o == ev, "R6 strobe", sample_vld_o, ev);
      if (ev) begin
         nsamp++;
         chk(sample_o == es, "R2/R4/R8 sample", sample_o, es);
      end
      chk(aligned_o == m_al, "R9 aligned", aligned_o, m_al);
   endtask

   function automatic logic [7:0] rnd(input int i, input int s);
      return 8'((i * 151 + s * 29) ^ (i * i) ^ (s << 3));
   endfunction

   function automatic bit tbit(input int k, input int d, input int W, input logic [11:0] p);
      if (k < d) return bit'(k & 1);
      return p[W - 1 - ((k - d) % W)];
   endfunction

   function automatic logic [11:0] pat_of(input int W);
      return (W == 6) ? 12'h026 : (W == 8) ? 12'h0B1 : 12'hB38;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [1:0] codes [4];
      codes = '{2'd1, 2'd2, 2'd0, 2'd3};
      rst_i = 1; word_i = '0; word_vld_i = 0; res_sel_i = 2'd1; train_i = 0;
      pattern_i = '0; m_res = 2'd1; m_tr = 0; m_al = 0; wr = 0; rd = 0; consec = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sample_vld_o == 0, "R1 vld", sample_vld_o, 0);
      chk(aligned_o == 0, "R1 aligned", aligned_o, 0);
      rst_i = 0;
      cyc(8'h00, 0);

      // stream sweep over all codes
      foreach (codes[c]) begin
         res_sel_i = codes[c];
         cyc(8'h00, 0);
         nsamp = 0;
         for (int i = 0; i < 48; i++) cyc(rnd(i, c), (i % 4) != 3);
         repeat (4) cyc(8'h00, 0);
         // R5 / R3: 36 words accepted
         chk(nsamp == 288 / wof(codes[c]), "R3/R5 sample count", nsamp, 288 / wof(codes[c]));
      end

      // R7: code change mid-stream drops the word in flight
      res_sel_i = 2'd1; cyc(8'hA5, 1);
      chk(sample_vld_o == 0, "R7 no strobe", sample_vld_o, 0);
      cyc(8'h3C, 1);
      chk(sample_o == 12'h03C, "R7 restart from next word", sample_o, 12'h03C);

      // training sweep over every start offset
      for (int r = 0; r < 3; r++) begin
         int W;
         W = wof(2'(r));
         for (int d = 0; d < W; d++) begin
            int k;
            bit held;
            res_sel_i = 2'(r + 1); cyc(8'h00, 0);
            res_sel_i = 2'(r);     cyc(8'h00, 0);
            pattern_i = pat_of(W);
            train_i = 1; cyc(8'h00, 0);
            k = 0;
            for (int i = 0; i < 48; i++) begin
               logic [7:0] w;
               bit v;
               v = (i % 4) != 3;
               w = '0;
               if (v) for (int j = 0; j < 8; j++) begin w = {w[6:0], tbit(k, d, W, pattern_i)}; k++; end
               cyc(w, v);
            end
            chk(aligned_o == 1, "R9 lock reached", aligned_o, 1);
            held = aligned_o;
            train_i = 0;
            for (int i = 0; i < 6; i++) cyc(rnd(i, d), 1);
            chk(aligned_o == held, "R10 hold untrained", aligned_o, held);
            if (d % 2 == 0) begin
               train_i = 1; cyc(8'h00, 0);
               chk(aligned_o == 0, "R10 train restart", aligned_o, 0);
               cyc(8'h00, 1); cyc(8'hFF, 1); cyc(8'h00, 0); cyc(8'h00, 0);
               train_i = 0; cyc(8'h00, 0);
            end else begin
               res_sel_i = 2'(r + 1); cyc(8'h00, 0);
               chk(aligned_o == 0, "R7 flush clears aligned", aligned_o, 0);
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule